// File: doc/BRIEF.md
# Serial Transmitter with Fractional Stop Length

This block turns parallel characters into an asynchronous serial bit stream. It runs from the system clock. A single-cycle enable, `tick16`, arrives at sixteen times the bit rate. The host writes one character at a time into a holding register with a load strobe. The block then sends a low start bit, the data bits least significant first, an optional parity bit and a high stop interval. The line idles high between characters.

Character length, parity mode, parity sense, stop length and clear-to-send gating are set by static mode inputs. The shifter copies them when it takes a character. The stop interval is set in sixteenths of a bit time, so a link can trim the idle gap between characters. When a held character is waiting, the next start bit follows the stop interval with no extra idle time. Two pulse commands switch the transmitter on and off. A switch-off waits until all queued work has left the line.

Top module: `fracstop_uart_tx`

## Requirements
- R1: After reset the line output `txd` is high, `tx_empty` is 1 and `tx_ready` is 0, because the transmitter starts switched off.
- R2: A character is sent as follows, with every bit held for 16 `tick16` pulses: a low start bit, then the data bits least significant first, where `cfg_len` 0, 1, 2 and 3 select 5, 6, 7 and 8 bits.
- R3: `cfg_parity` 0 appends a computed parity bit, where `cfg_odd` 0 makes the count of ones across data and parity even, and 1 makes it odd. `cfg_parity` 1 appends a fixed bit equal to `cfg_odd`. `cfg_parity` 2 or 3 appends no parity bit.
- R4: The stop interval is high. For `cfg_stop` codes 0 to 7 it lasts 9+code sixteenths of a bit time, and for codes 8 to 15 it lasts 17+code sixteenths. A held character's start bit begins right after the interval ends.
- R5: With 5-bit characters, stop codes 0 to 7 are lengthened by 8 sixteenths. Codes 8 to 15 are unchanged.
- R6: A load strobe is ignored while `tx_ready` is 0. In particular, a switched-off transmitter accepts no character and the line stays idle.
- R7: `tx_ready` is 1 when the transmitter is switched on, no switch-off is pending and the holding register is empty. `tx_empty` is 1 only when both the holding register and the shifter are empty.
- R8: When `cfg_cts_en` is 1, a character starts only while `cts` is 1. `cts` is looked at only when a character would start, so dropping it mid-character does not cut that character short.
- R9: A `cmd_disable` pulse received mid-character lets the current character and any held character finish. `tx_ready` drops at once, and the transmitter switches off only once it is empty. `cmd_enable` switches it back on.
- R10: All line timing advances only on `tick16`. With the enable pulsing every N clocks, every duration stretches by N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| cmd_enable | input | 1 | Pulse: switch the transmitter on |
| cmd_disable | input | 1 | Pulse: switch off once all queued work is sent |
| load | input | 1 | Pulse: write `load_data` into the holding register |
| load_data | input | 8 | Character to send; unused upper bits ignored |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_parity | input | 2 | Parity mode: computed, fixed, none |
| cfg_odd | input | 1 | Parity sense, or the fixed parity level |
| cfg_stop | input | 4 | Stop interval code in sixteenths |
| cfg_cts_en | input | 1 | Make character start depend on `cts` |
| cts | input | 1 | Clear-to-send, active high |
| txd | output | 1 | Serial line output, idle high |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
The block has no size parameters, so the bench builds it as it stands. It keeps the sixteen-tick bit time and mostly runs with `tick16` held high, so one bit lasts sixteen clocks. That makes it cheap to sweep every length, parity mode and sense, and every one of the sixteen stop codes at both 5-bit and 8-bit length, with characters sent back to back so that each stop interval is measured to the exact clock. One extra run with a divided tick checks that the timing scales. Directed runs cover clear-to-send holding a character back, a switch-off that has to drain two characters, and loads refused while switched off.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

  localparam int TICKS_PER_BIT = 16;
  localparam int SUB_W         = $clog2(2 * TICKS_PER_BIT);
  localparam int STOP_W        = SUB_W + 1;
  localparam int DATA_W        = 8;
  localparam int IDX_W         = $clog2(DATA_W);
  localparam int NB_W          = IDX_W + 1;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_CALC  = 2'b00,
    PAR_FIXED = 2'b01,
    PAR_OFF   = 2'b10,
    PAR_OFF2  = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] par_mode;
    logic       par_odd;
    logic [3:0] stop_code;
  } frame_cfg_t;

  // Number of data bits for a length code.
  function automatic logic [NB_W-1:0] char_bits(input logic [1:0] len);
    return NB_W'(5) + NB_W'(len);
  endfunction

  // Stop interval in ticks (sixteenths of a bit time).
  function automatic logic [STOP_W-1:0] stop_ticks(input logic [3:0] code,
                                                   input logic [1:0] len);
    logic [STOP_W-1:0] base;
    base = code[3] ? STOP_W'(25) + STOP_W'(code[2:0])
                   : STOP_W'(9)  + STOP_W'(code[2:0]);
    if (!code[3] && len == 2'b00) base = base + STOP_W'(8);
    return base;
  endfunction

  function automatic logic parity_on(input logic [1:0] mode);
    return (mode == PAR_CALC) || (mode == PAR_FIXED);
  endfunction

  function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] len);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (NB_W'(i) < char_bits(len));
    return m;
  endfunction

  // Level of the parity bit.
  function automatic logic parity_level(input logic [DATA_W-1:0] data,
                                        input logic [1:0] len,
                                        input logic [1:0] mode,
                                        input logic odd);
    if (mode == PAR_FIXED) return odd;
    return (^(data & len_mask(len))) ^ odd;
  endfunction

endpackage

// File: rtl/fstx_hold_ctrl.sv
module fstx_hold_ctrl
  import fstx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              take,
  input  logic              shifter_busy,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic              tx_enabled,
  output logic              accept_rdy
);

  logic en_q, off_pend_q, full_q;
  logic [DATA_W-1:0] data_q;
  logic drained;

  assign drained    = !full_q && !shifter_busy;
  assign accept_rdy = en_q && !off_pend_q && !full_q;

  // Enable and disable sequencing; enable has priority.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      off_pend_q <= 1'b0;
    end else if (cmd_enable) begin
      en_q       <= 1'b1;
      off_pend_q <= 1'b0;
    end else if (cmd_disable && en_q) begin
      off_pend_q <= 1'b1;
    end else if (off_pend_q && drained) begin
      en_q       <= 1'b0;
      off_pend_q <= 1'b0;
    end
  end

  // Holding register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (load && accept_rdy) begin
      full_q <= 1'b1;
      data_q <= load_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign hold_full  = full_q;
  assign hold_data  = data_q;
  assign tx_enabled = en_q;

endmodule

// File: rtl/fstx_shifter.sv
module fstx_shifter
  import fstx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  frame_cfg_t        cfg,
  input  logic              cts_en,
  input  logic              cts,
  output logic              take,
  output logic              busy,
  output logic              txd,
  output logic              in_stop,
  output logic [SUB_W-1:0]  sub_cnt,
  output logic [STOP_W-1:0] stop_len
);

  tx_state_e         state_q;
  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic [NB_W-1:0]   nbits_q;
  logic              par_en_q, par_bit_q;
  logic [STOP_W-1:0] stop_len_q;

  logic last_sub, stop_done, slot_free, cts_ok, last_data;

  assign last_sub  = (sub_q == SUB_W'(TICKS_PER_BIT - 1));
  assign stop_done = (sub_q == SUB_W'(stop_len_q - STOP_W'(1)));
  assign last_data = (NB_W'(idx_q) == nbits_q - NB_W'(1));
  assign slot_free = (state_q == TX_IDLE) || (state_q == TX_STOP && stop_done);
  assign cts_ok    = !cts_en || cts;
  assign take      = tick && hold_full && slot_free && cts_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TX_IDLE;
      sub_q      <= '0;
      idx_q      <= '0;
      sh_q       <= '0;
      nbits_q    <= NB_W'(DATA_W);
      par_en_q   <= 1'b0;
      par_bit_q  <= 1'b0;
      stop_len_q <= STOP_W'(TICKS_PER_BIT);
    end else if (take) begin
      state_q    <= TX_START;
      sub_q      <= '0;
      idx_q      <= '0;
      sh_q       <= hold_data;
      nbits_q    <= char_bits(cfg.len);
      par_en_q   <= parity_on(cfg.par_mode);
      par_bit_q  <= parity_level(hold_data, cfg.len, cfg.par_mode, cfg.par_odd);
      stop_len_q <= stop_ticks(cfg.stop_code, cfg.len);
    end else if (tick) begin
      unique case (state_q)
        TX_IDLE: sub_q <= '0;
        TX_START: begin
          sub_q <= sub_q + SUB_W'(1);
          if (last_sub) begin
            state_q <= TX_DATA;
            sub_q   <= '0;
          end
        end
        TX_DATA: begin
          sub_q <= sub_q + SUB_W'(1);
          if (last_sub) begin
            sub_q <= '0;
            sh_q  <= sh_q >> 1;
            if (last_data) begin
              idx_q   <= '0;
              state_q <= par_en_q ? TX_PARITY : TX_STOP;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        TX_PARITY: begin
          sub_q <= sub_q + SUB_W'(1);
          if (last_sub) begin
            state_q <= TX_STOP;
            sub_q   <= '0;
          end
        end
        TX_STOP: begin
          sub_q <= sub_q + SUB_W'(1);
          if (stop_done) begin
            state_q <= TX_IDLE;
            sub_q   <= '0;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      TX_START:  txd = 1'b0;
      TX_DATA:   txd = sh_q[0];
      TX_PARITY: txd = par_bit_q;
      default:   txd = 1'b1;
    endcase
  end

  assign busy     = (state_q != TX_IDLE);
  assign in_stop  = (state_q == TX_STOP);
  assign sub_cnt  = sub_q;
  assign stop_len = stop_len_q;

endmodule

// File: rtl/fracstop_uart_tx.sv
module fracstop_uart_tx
  import fstx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       cmd_enable,
  input  logic       cmd_disable,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_odd,
  input  logic [3:0] cfg_stop,
  input  logic       cfg_cts_en,
  input  logic       cts,
  output logic       txd,
  output logic       tx_ready,
  output logic       tx_empty
);

  frame_cfg_t        cfg;
  logic              char_start, shifter_busy, hold_full, tx_enabled, in_stop;
  logic [DATA_W-1:0] hold_data;
  logic [SUB_W-1:0]  sub_cnt;
  logic [STOP_W-1:0] stop_len;

  assign cfg.len       = cfg_len;
  assign cfg.par_mode  = cfg_parity;
  assign cfg.par_odd   = cfg_odd;
  assign cfg.stop_code = cfg_stop;

  fstx_hold_ctrl u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_enable   (cmd_enable),
    .cmd_disable  (cmd_disable),
    .load         (load),
    .load_data    (load_data),
    .take         (char_start),
    .shifter_busy (shifter_busy),
    .hold_full    (hold_full),
    .hold_data    (hold_data),
    .tx_enabled   (tx_enabled),
    .accept_rdy   (tx_ready)
  );

  fstx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .cfg       (cfg),
    .cts_en    (cfg_cts_en),
    .cts       (cts),
    .take      (char_start),
    .busy      (shifter_busy),
    .txd       (txd),
    .in_stop   (in_stop),
    .sub_cnt   (sub_cnt),
    .stop_len  (stop_len)
  );

  assign tx_empty = !hold_full && !shifter_busy;

endmodule

// File: rtl/fstx_checks.sv
module fstx_checks
  import fstx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick16,
  input logic              txd,
  input logic              tx_ready,
  input logic              tx_empty,
  input logic              char_start,
  input logic              hold_full,
  input logic              tx_enabled,
  input logic              cfg_cts_en,
  input logic              cts,
  input logic              in_stop,
  input logic [SUB_W-1:0]  sub_cnt,
  input logic [STOP_W-1:0] stop_len
);

  a_r7_empty_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  a_r6_refused_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !hold_full) |=> !hold_full);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    char_start |=> !txd);

  a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (char_start && cfg_cts_en) |-> cts);

  a_r9_off_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_enabled) |-> $past(tx_empty));

  a_r10_still_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(txd));

  a_r4_stop_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> (STOP_W'(sub_cnt) < stop_len));

endmodule

bind fracstop_uart_tx fstx_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick16     (tick16),
  .txd        (txd),
  .tx_ready   (tx_ready),
  .tx_empty   (tx_empty),
  .char_start (char_start),
  .hold_full  (hold_full),
  .tx_enabled (tx_enabled),
  .cfg_cts_en (cfg_cts_en),
  .cts        (cts),
  .in_stop    (in_stop),
  .sub_cnt    (sub_cnt),
  .stop_len   (stop_len)
);

// File: tb/fracstop_uart_tx_test.sv
`timescale 1ns/1ps
module fracstop_uart_tx_test;

  localparam int HMAX = 1 << 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b1;
  logic       cmd_enable = 1'b0, cmd_disable = 1'b0, load = 1'b0;
  logic [7:0] load_data = '0;
  logic [1:0] cfg_len = 2'd3, cfg_parity = 2'd2;
  logic       cfg_odd = 1'b0;
  logic [3:0] cfg_stop = 4'd7;
  logic       cfg_cts_en = 1'b0, cts = 1'b1;
  logic       txd, tx_ready, tx_empty;

  int  checks = 0, fails = 0, cyc = 0, div = 1, div_cnt = 0;
  bit  done = 0;
  logic hist [0:HMAX-1];

  fracstop_uart_tx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cmd_enable(cmd_enable),
    .cmd_disable(cmd_disable), .load(load), .load_data(load_data),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_odd(cfg_odd),
    .cfg_stop(cfg_stop), .cfg_cts_en(cfg_cts_en), .cts(cts),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (cyc < HMAX) hist[cyc] = txd;

  // tick16 generator, one pulse every div clocks
  always @(negedge clk) begin
    if (div <= 1) tick16 = 1'b1;
    else begin
      tick16 = (div_cnt == div - 1);
      div_cnt = (div_cnt + 1 >= div) ? 0 : div_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !tx_ready; i++) @(negedge clk);
  endtask

  task automatic wait_empty();
    @(negedge clk);
    for (int i = 0; i < 20000 && !tx_empty; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_load(input logic [7:0] d);
    load = 1'b1; load_data = d;
    @(negedge clk);
    load = 1'b0;
  endtask

  function automatic int find_fall(input int from);
    for (int i = from + 1; i < cyc && i < HMAX; i++)
      if (hist[i-1] === 1'b1 && hist[i] === 1'b0) return i;
    return -1;
  endfunction

  function automatic int stop_sixteenths(input int code, input int nbits);
    int s;
    if (code < 8) s = 9 + code + ((nbits == 5) ? 8 : 0);
    else s = 25 + (code - 8);
    return s;
  endfunction

  // Decode one frame from the line history starting at t0.
  task automatic check_frame(input int t0, input logic [7:0] d, input int nbits,
                             input int pm, input bit po, input int sc,
                             input bit follow, output int tnext);
    int got, exp, ones, pexp, pon, ss, s, bad;
    got = 0; exp = 0; ones = 0; tnext = -1;
    chk(t0 >= 0 && hist[t0 + 8*div] === 1'b0, "R2 start bit low", t0, 0);
    if (t0 < 0) return;
    for (int k = 0; k < nbits; k++) begin
      if (hist[t0 + div*(16*(1+k)+8)] === 1'b1) got |= (1 << k);
      if (d[k]) begin exp |= (1 << k); ones++; end
    end
    chk(got == exp, "R2 data bits LSB first", got, exp);
    pon = (pm < 2);
    if (pon) begin
      if (pm == 1) pexp = po;
      else pexp = (ones % 2) ^ po;
      got = (hist[t0 + div*(16*(1+nbits)+8)] === 1'b1);
      chk(got == pexp, "R3 parity bit", got, pexp);
    end
    s  = stop_sixteenths(sc, nbits);
    ss = t0 + div*16*(1 + nbits + pon);
    bad = 0;
    for (int i = 0; i < s*div; i++) if (hist[ss+i] !== 1'b1) bad++;
    if (nbits == 5 && sc < 8)
      chk(bad == 0, "R5 widened stop high", bad, 0);
    else
      chk(bad == 0, "R4 stop interval high", bad, 0);
    if (follow) begin
      chk(hist[ss + s*div] === 1'b0, "R4 next start right after stop", ss + s*div, sc);
      tnext = ss + s*div;
    end
  endtask

  task automatic run_pair(input logic [7:0] d0, input logic [7:0] d1, input int len,
                          input int pm, input bit po, input int sc);
    int from, t0, t1, tx;
    cfg_len = 2'(len); cfg_parity = 2'(pm); cfg_odd = po; cfg_stop = 4'(sc);
    from = cyc;
    wait_ready(); pulse_load(d0);
    wait_ready(); pulse_load(d1);
    wait_empty();
    t0 = find_fall(from);
    check_frame(t0, d0, len + 5, pm, po, sc, 1'b1, t1);
    if (t1 >= 0) check_frame(t1, d1, len + 5, pm, po, sc, 1'b0, tx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int t0, tx, from;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 line idle high", txd, 1);
    chk(tx_empty == 1'b1, "R1 empty after reset", tx_empty, 1);
    chk(tx_ready == 1'b0, "R1 not ready while off", tx_ready, 0);

    // R6 load while switched off is ignored
    from = cyc;
    pulse_load(8'h55);
    repeat (60) @(negedge clk);
    chk(find_fall(from) < 0, "R6 no frame while off", find_fall(from), -1);
    chk(tx_empty == 1'b1, "R6 still empty while off", tx_empty, 1);

    cmd_enable = 1'b1; @(negedge clk); cmd_enable = 1'b0;
    chk(tx_ready == 1'b1, "R7 ready once switched on", tx_ready, 1);

    // R7 status right after a load
    cfg_len = 2'd3; cfg_parity = 2'd2; cfg_stop = 4'd15;
    from = cyc;
    pulse_load(8'hA5);
    chk(tx_empty == 1'b0, "R7 empty low after load", tx_empty, 0);
    wait_empty();
    chk(tx_empty == 1'b1 && txd == 1'b1, "R7 empty again after frame", tx_empty, 1);
    t0 = find_fall(from);
    check_frame(t0, 8'hA5, 8, 2, 0, 15, 1'b0, tx);

    // R2/R3 sweep over lengths, parity modes and senses
    for (int len = 0; len < 4; len++)
      for (int pm = 0; pm < 4; pm++)
        for (int po = 0; po < 2; po++)
          run_pair(8'(8'h3C + 37*(len*8+pm*2+po)), 8'(8'hC3 ^ (13*(len+pm+po))),
                   len, pm, po[0], 7);

    // R4/R5 stop code sweep at 5-bit and 8-bit length
    for (int sc = 0; sc < 16; sc++) begin
      run_pair(8'h15, 8'h0A, 0, 2, 0, sc);
      run_pair(8'h96, 8'h69, 3, 0, 1, sc);
    end

    // R10 divided tick
    div = 3;
    run_pair(8'h4D, 8'hB2, 2, 0, 0, 9);
    div = 1;
    repeat (4) @(negedge clk);

    // R8 clear-to-send gating
    cfg_cts_en = 1'b1; cts = 1'b0;
    cfg_len = 2'd3; cfg_parity = 2'd2; cfg_stop = 4'd7;
    from = cyc;
    pulse_load(8'h81);
    repeat (100) @(negedge clk);
    chk(find_fall(from) < 0, "R8 held back while cts low", find_fall(from), -1);
    chk(tx_ready == 1'b0 && tx_empty == 1'b0, "R8 character waiting",
        {tx_ready, tx_empty}, 0);
    cts = 1'b1;
    repeat (40) @(negedge clk);
    cts = 1'b0;
    wait_empty();
    t0 = find_fall(from);
    check_frame(t0, 8'h81, 8, 2, 0, 7, 1'b0, tx);
    chk(tx_empty == 1'b1, "R8 character finished after cts drop", tx_empty, 1);
    cfg_cts_en = 1'b0; cts = 1'b1;

    // R9 deferred switch-off with two characters queued
    cfg_parity = 2'd0; cfg_odd = 1'b1; cfg_stop = 4'd3;
    from = cyc;
    wait_ready(); pulse_load(8'h12);
    wait_ready(); pulse_load(8'hED);
    cmd_disable = 1'b1; @(negedge clk); cmd_disable = 1'b0;
    chk(tx_ready == 1'b0, "R9 ready drops at switch-off", tx_ready, 0);
    wait_empty();
    t0 = find_fall(from);
    check_frame(t0, 8'h12, 8, 0, 1, 3, 1'b1, tx);
    if (tx >= 0) check_frame(tx, 8'hED, 8, 0, 1, 3, 1'b0, t0);
    chk(tx_ready == 1'b0, "R9 off after draining", tx_ready, 0);
    from = cyc;
    pulse_load(8'h77);
    repeat (60) @(negedge clk);
    chk(find_fall(from) < 0 && tx_empty, "R6 load refused after switch-off",
        find_fall(from), -1);
    cmd_enable = 1'b1; @(negedge clk); cmd_enable = 1'b0;
    chk(tx_ready == 1'b1, "R9 enable restores ready", tx_ready, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule